// File: doc/BRIEF.md
# Seven-Level Priority Interrupt Controller

This block arbitrates among seven interrupt levels, numbered 1 to 7. Level 1 has the highest priority. For each level it holds three bits: an active bit, a request bit and an in-progress bit. It also holds one system-enable bit. Software changes these bits with an 18-bit command word. The command carries seven function bits and a seven-bit level mask that selects which levels the functions act on. A command that sets any reserved bit is refused and leaves every bit as it was.

The arbiter looks for a level whose request bit and active bit are both set. It offers the lowest-numbered such level, but only when the system is enabled and only when that level outranks every level already in progress. While a level is offered, the block also presents the address of its interrupt instruction. That address is the base input plus 32 plus twice the level number. A grant acknowledge marks the offered level in progress. A dismiss clears the highest-priority level in progress.

A status word shows the whole state in a fixed layout.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every active, request and in-progress bit is 0, the system-enable bit is 0, no level is offered and `cmd_bad` is 0.
- R2: Command bit 13 (clear-all) zeroes all active, request and in-progress bits and the system-enable bit. The other function bits of the same command then act on the cleared state.
- R3: Bit 11 drops the request bits of the masked levels and bit 12 sets them. If both are set, the requests end up set. Mask bit 6 selects level 1 and mask bit 0 selects level 7.
- R4: Bit 9 enables the system and bit 10 disables it. If both are set, the system ends up disabled.
- R5: Bit 7 sets the active bits of the masked levels and bit 8 clears them. If both are set, the active bits end up cleared.
- R6: A command with any of bits 17..14 set changes no state. One cycle after the command, `cmd_bad` pulses high for one cycle.
- R7: `irq_pend` is high and `irq_level` equals N when all of the following hold: N is the lowest-numbered level with both request and active set, the system is enabled, and no level numbered N or lower is in progress.
- R8: While `irq_pend` is high, `irq_addr` equals `base_addr + 32 + 2*irq_level`, taken modulo 2^ADDR_W.
- R9: When `grant_ack` is high while a level is offered, the in-progress bit of that level is set at the next clock edge. Its request bit is left as it was.
- R10: `dismiss` clears only the lowest-numbered in-progress bit. With no level in progress, it changes nothing.
- R11: In one cycle, a command takes precedence over dismiss, and dismiss takes precedence over grant. The operation that loses has no effect in that cycle.
- R12: The `status` layout is: bits 24..18 hold the request bits, bits 14..8 the in-progress bits, bit 7 the system enable and bits 6..0 the active bits. In each field level 1 occupies the highest bit. Bits 17..15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Apply `cmd_word` this cycle |
| cmd_word | input | 18 | Command: mask in 6..0, functions in 13..7, reserved 17..14 |
| dismiss | input | 1 | Clear the highest-priority level in progress |
| grant_ack | input | 1 | Accept the offered level |
| base_addr | input | ADDR_W | Base of the interrupt instruction table |
| irq_pend | output | 1 | A level is being offered |
| irq_level | output | 3 | Offered level, 1..7 (0 when none is offered) |
| irq_addr | output | ADDR_W | Interrupt instruction address of the offered level |
| status | output | 25 | State readback (see R12) |
| cmd_bad | output | 1 | Pulse one cycle after a refused command |

## Verification
The assertions assume that `cmd_valid`, `dismiss` and `grant_ack` are known (never X) whenever reset is released, and that `base_addr` holds steady across the edge at which an offer is sampled. The stimulus drives every input on the falling edge only, so inputs never change near the sampling edge. It fires all three operations at the same time on purpose, so that the precedence between them is exercised. Reserved-bit commands are mixed into the random stream at a low rate, so most commands are legal and change state.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int unsigned NLEV    = 7;
  localparam int unsigned CMD_W   = 18;
  localparam int unsigned STAT_W  = 25;
  localparam int unsigned LVL_W   = $clog2(NLEV + 1);
  // function bit positions of the command word
  localparam int unsigned B_LVL_ON  = 7;
  localparam int unsigned B_LVL_OFF = 8;
  localparam int unsigned B_SYS_ON  = 9;
  localparam int unsigned B_SYS_OFF = 10;
  localparam int unsigned B_REQ_DRP = 11;
  localparam int unsigned B_REQ_SET = 12;
  localparam int unsigned B_CLR_ALL = 13;
  localparam int unsigned B_RSV_LO  = 14;
  // status field tops (level 1 sits at the top bit of each field)
  localparam int unsigned S_REQ_TOP = 24;
  localparam int unsigned S_IP_TOP  = 14;
  localparam int unsigned S_ON      = 7;
  localparam int unsigned S_ACT_TOP = 6;
endpackage

// File: rtl/pirq_first_set.sv
module pirq_first_set #(
  parameter int unsigned W     = 7,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic [W-1:0]     first_oh,
  output logic [IDX_W-1:0] first_idx,
  output logic             found
);
  always_comb begin
    first_oh  = '0;
    first_idx = '0;
    found     = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        first_oh  = '0;
        first_oh[i] = 1'b1;
        first_idx = IDX_W'(i);
        found     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pirq_cmd_apply.sv
module pirq_cmd_apply
  import pirq_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  input  logic [NLEV-1:0]  act_q,
  input  logic [NLEV-1:0]  req_q,
  input  logic [NLEV-1:0]  ip_q,
  input  logic             on_q,
  output logic [NLEV-1:0]  act_n,
  output logic [NLEV-1:0]  req_n,
  output logic [NLEV-1:0]  ip_n,
  output logic             on_n,
  output logic             illegal
);
  logic [NLEV-1:0] sel;
  logic [NLEV-1:0] act_c, req_c;
  logic            on_c;

  // mask bit NLEV-1 selects level 1 (index 0)
  for (genvar i = 0; i < NLEV; i++) begin : g_sel
    assign sel[i] = cmd[NLEV-1-i];
  end

  assign illegal = |cmd[CMD_W-1:B_RSV_LO];

  always_comb begin
    act_c = cmd[B_CLR_ALL] ? '0 : act_q;
    req_c = cmd[B_CLR_ALL] ? '0 : req_q;
    on_c  = cmd[B_CLR_ALL] ? 1'b0 : on_q;
    ip_n  = cmd[B_CLR_ALL] ? '0 : ip_q;
    req_n = (req_c & ~(cmd[B_REQ_DRP] ? sel : '0)) | (cmd[B_REQ_SET] ? sel : '0);
    on_n  = (on_c | cmd[B_SYS_ON]) & ~cmd[B_SYS_OFF];
    act_n = (act_c | (cmd[B_LVL_ON] ? sel : '0)) & ~(cmd[B_LVL_OFF] ? sel : '0);
  end
endmodule

// File: rtl/pirq_arbiter.sv
module pirq_arbiter
  import pirq_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NLEV-1:0]         act,
  input  logic [NLEV-1:0]         req,
  input  logic [NLEV-1:0]         ip,
  input  logic                    on,
  output logic                    pend,
  output logic [NLEV-1:0]         win_oh,
  output logic [$clog2(NLEV)-1:0] win_idx
);
  logic [NLEV-1:0] blocked, cand;

  // a level is blocked by any in-progress level of equal or higher priority
  assign blocked[0] = ip[0];
  for (genvar i = 1; i < NLEV; i++) begin : g_blk
    assign blocked[i] = blocked[i-1] | ip[i];
  end

  assign cand = req & act & ~blocked & {NLEV{on}};

  pirq_first_set #(.W(NLEV)) u_pick (
    .vec(cand), .first_oh(win_oh), .first_idx(win_idx), .found(pend)
  );

  assert_winner_unique_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh) && (pend == (win_oh != '0)));
  assert_winner_eligible_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (on && ((win_oh & req & act) == win_oh) && ((win_oh & ip) == '0)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pirq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 18,
  parameter int unsigned VEC_OFS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [17:0]       cmd_word,
  input  logic              dismiss,
  input  logic              grant_ack,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              irq_pend,
  output logic [2:0]        irq_level,
  output logic [ADDR_W-1:0] irq_addr,
  output logic [24:0]       status,
  output logic              cmd_bad
);
  localparam int unsigned IDX_W = $clog2(NLEV);
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(VEC_OFS);

  logic [NLEV-1:0] act_q, req_q, ip_q, act_d, req_d, ip_d;
  logic            on_q, on_d, bad_d, st_en;
  logic [NLEV-1:0] c_act, c_req, c_ip;
  logic            c_on, c_ill;
  logic [NLEV-1:0] win_oh, dis_oh;
  logic [IDX_W-1:0] win_idx, dis_idx;
  logic            dis_any;

  pirq_cmd_apply u_cmd (
    .cmd(cmd_word), .act_q(act_q), .req_q(req_q), .ip_q(ip_q), .on_q(on_q),
    .act_n(c_act), .req_n(c_req), .ip_n(c_ip), .on_n(c_on), .illegal(c_ill)
  );

  pirq_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .act(act_q), .req(req_q), .ip(ip_q), .on(on_q),
    .pend(irq_pend), .win_oh(win_oh), .win_idx(win_idx)
  );

  pirq_first_set #(.W(NLEV)) u_dis (
    .vec(ip_q), .first_oh(dis_oh), .first_idx(dis_idx), .found(dis_any)
  );

  assign irq_level = irq_pend ? 3'(win_idx + 1'b1) : 3'd0;
  assign irq_addr  = base_addr + OFS + ADDR_W'({irq_level, 1'b0});

  // next state: command beats dismiss beats grant
  always_comb begin
    act_d = act_q;
    req_d = req_q;
    ip_d  = ip_q;
    on_d  = on_q;
    bad_d = 1'b0;
    if (cmd_valid) begin
      if (c_ill) begin
        bad_d = 1'b1;
      end else begin
        act_d = c_act;
        req_d = c_req;
        ip_d  = c_ip;
        on_d  = c_on;
      end
    end else if (dismiss) begin
      ip_d = ip_q & ~dis_oh;
    end else if (grant_ack && irq_pend) begin
      ip_d = ip_q | win_oh;
    end
  end

  assign st_en = cmd_valid | dismiss | grant_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      req_q <= '0;
      ip_q  <= '0;
      on_q  <= 1'b0;
    end else if (st_en) begin
      act_q <= act_d;
      req_q <= req_d;
      ip_q  <= ip_d;
      on_q  <= on_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_bad <= 1'b0;
    else        cmd_bad <= bad_d;
  end

  always_comb begin
    status = '0;
    for (int i = 0; i < NLEV; i++) begin
      status[S_REQ_TOP-i] = req_q[i];
      status[S_IP_TOP-i]  = ip_q[i];
      status[S_ACT_TOP-i] = act_q[i];
    end
    status[S_ON] = on_q;
  end

  assert_reject_keeps_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_word[17:14] != '0)) |=> (cmd_bad && $stable(status)));
  assert_grant_marks_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !dismiss && grant_ack && irq_pend) |=>
      status[S_IP_TOP - ($past(irq_level) - 1)]);
  assert_dismiss_one_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && dismiss && (ip_q != '0)) |=>
      ($countones(ip_q) == $countones($past(ip_q)) - 1));
  assert_dismiss_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && dismiss && (ip_q == '0)) |=> $stable(status));
  assert_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |-> (irq_addr - base_addr == OFS + ADDR_W'(2 * irq_level)));
endmodule

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  localparam int AW = 18;
  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, dismiss, grant_ack;
  logic [17:0] cmd_word;
  logic [AW-1:0] base_addr;
  logic irq_pend, cmd_bad;
  logic [2:0] irq_level;
  logic [AW-1:0] irq_addr;
  logic [24:0] status;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .dismiss(dismiss), .grant_ack(grant_ack), .base_addr(base_addr),
    .irq_pend(irq_pend), .irq_level(irq_level), .irq_addr(irq_addr),
    .status(status), .cmd_bad(cmd_bad)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  // reference state, indexed by level number 1..7
  bit m_act[1:7], m_req[1:7], m_ip[1:7];
  bit m_on, m_bad;

  function automatic int ref_level();
    for (int n = 1; n <= 7; n++) begin
      if (m_ip[n]) return 0;
      if (m_on && m_req[n] && m_act[n]) return n;
    end
    return 0;
  endfunction

  function automatic logic [24:0] ref_status();
    logic [24:0] s = '0;
    for (int n = 1; n <= 7; n++) begin
      s[25 - n] = m_req[n];
      s[15 - n] = m_ip[n];
      s[7 - n]  = m_act[n];
    end
    s[7] = m_on;
    return s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 1; n <= 7; n++) begin m_act[n] = 0; m_req[n] = 0; m_ip[n] = 0; end
      m_on = 0; m_bad = 0;
    end else begin
      int lv;
      lv = ref_level();
      m_bad = 0;
      if (cmd_valid) begin
        if (cmd_word[17:14] != 0) m_bad = 1;
        else begin
          if (cmd_word[13]) begin
            for (int n = 1; n <= 7; n++) begin m_act[n] = 0; m_req[n] = 0; m_ip[n] = 0; end
            m_on = 0;
          end
          for (int n = 1; n <= 7; n++) if (cmd_word[7 - n]) begin
            if (cmd_word[11]) m_req[n] = 0;
            if (cmd_word[12]) m_req[n] = 1;
            if (cmd_word[7])  m_act[n] = 1;
            if (cmd_word[8])  m_act[n] = 0;
          end
          if (cmd_word[9])  m_on = 1;
          if (cmd_word[10]) m_on = 0;
        end
      end else if (dismiss) begin
        for (int n = 1; n <= 7; n++) if (m_ip[n]) begin m_ip[n] = 0; break; end
      end else if (grant_ack && lv != 0) begin
        m_ip[lv] = 1;
      end
    end
  end

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    int lv;
    lv = ref_level();
    check({tag, " R12 status"}, 32'(status), 32'(ref_status()));
    check("R7 offer", {28'd0, irq_pend, irq_level}, {28'd0, lv != 0, 3'(lv)});
    if (lv != 0) check("R8 address", 32'(irq_addr), 32'(AW'(base_addr + 32 + 2 * lv)));
    check("R6 cmd_bad", 32'(cmd_bad), 32'(m_bad));
  end

  task automatic idle();
    cmd_valid = 0; dismiss = 0; grant_ack = 0;
  endtask

  task automatic cmd(string t, logic [17:0] w);
    @(negedge clk); tag = t; idle(); cmd_valid = 1; cmd_word = w;
    @(negedge clk); idle();
  endtask

  task automatic op(string t, bit d, bit g);
    @(negedge clk); tag = t; idle(); dismiss = d; grant_ack = g;
    @(negedge clk); idle();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(); cmd_word = 0; base_addr = 18'o1000; rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset status", 32'(status), 0);
    check("R1 reset offer", {31'd0, irq_pend}, 0);
    check("R1 reset cmd_bad", {31'd0, cmd_bad}, 0);
    rst_n = 1;
    cmd("R3", 18'o10000 | 7'b0101010);        // R3: request levels 2,4,6
    cmd("R5", 18'o00200 | 7'b0111111);        // R5: levels 2..7 on
    cmd("R4", 18'o01000);                     // R4: system on -> level 2 offered
    check("R7 level 2 offered", 32'(irq_level), 2);
    op("R9", 0, 1);                           // R9: grant level 2
    check("R9 ip level 2", 32'(status[13]), 1);
    check("R7 blocked below", {31'd0, irq_pend}, 0);
    cmd("R3", 18'o10000 | 7'b1000000);        // request level 1 (inactive)
    cmd("R5", 18'o00200 | 7'b1000000);        // activate level 1 -> preempts
    check("R7 level 1 over ip 2", 32'(irq_level), 1);
    op("R11", 1, 1);                          // R11: dismiss wins over grant
    check("R11 grant ignored", 32'(status[14:8]), 0);
    op("R10", 1, 0);                          // R10: dismiss with none in progress
    cmd("R5", 18'o00600 | 7'b0000010);        // R5: on+off -> off wins
    cmd("R4", 18'o03000);                     // R4: on+off -> off wins
    check("R4 off wins", 32'(status[7]), 0);
    cmd("R3", 18'o14000 | 7'b0000001);        // R3: drop+set -> set wins
    cmd("R6", 18'o40000 | 18'o20177);         // R6: reserved bit -> refused
    cmd("R2", 18'o21200 | 7'b0000100);        // R2: clear then level 5 on, sys on
    check("R2 cleared", 32'(status), 32'(1 << 7) | 32'(1 << 2));
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      idle();
      tag = "R11";
      if ($urandom_range(0, 15) == 0) base_addr = AW'($urandom);
      cmd_valid = ($urandom_range(0, 3) == 0);
      dismiss   = ($urandom_range(0, 4) == 0);
      grant_ack = ($urandom_range(0, 1) == 0);
      cmd_word  = 18'($urandom);
      if ($urandom_range(0, 7) != 0) cmd_word[17:14] = 0;
      if ($urandom_range(0, 5) != 0) cmd_word[13] = 0;
    end
    @(negedge clk); idle();
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule